// File: doc/BRIEF.md
# Threaded Windowed Register File

This block holds the integer registers of many hardware threads in one shared storage array and turns each architectural register number into a physical storage address. Every thread owns a 64-entry slice of the array. The physical address is the thread number concatenated with a 6-bit slot number inside that slice, so the threads can never reach each other's registers.

Inside a slice there are eight globals, a trap base slot, seven microcode scratch slots and a circular area of three 16-slot register windows. A window pointer input selects the active window. The outs of one window share storage with the ins of the window below it, so after a call moves the pointer down, a value the caller left in an out register is found by the callee in the matching in register. Two read ports and one write port serve the pipeline. Each stored word carries a parity bit, and a parity mismatch is reported next to the read data.

Top module: `regwin_regfile`

## Requirements
- R1: Storage is split per thread. The physical address is {thread, slot}, with a 6-bit slot. A write by one thread never changes a value read by another thread.
- R2: Architectural r1..r7 are globals at slots 1..7. They are the same registers whatever the window pointer is.
- R3: Architectural r16..r31 (locals, then ins) under window pointer w (0..2) use slot 16 + 16*w + (r - 16).
- R4: Outside microcode mode, architectural r8..r15 (outs) under pointer w use the in slots of window (w + 2) mod 3. The pointer value 0 therefore wraps to window 2. An out written under w is read back as r(n+16) under pointer (w + 2) mod 3.
- R5: While the microcode-mode input is high, r8..r15 select slots 8..15 directly. Slot 8 is the trap base register and slots 9..15 are scratch. Outside microcode mode these slots cannot be written.
- R6: Reading r0 on either port returns zero with the error flag low. A write to r0 changes no stored register.
- R7: Read data appears one clock after the read address. A read of a slot in the same cycle as a write to it returns the value it held before the write.
- R8: Each stored word keeps an even parity bit computed at write time. The read error flag is high exactly when the word and parity bit read back do not match, so values written through the write port read back with the flag low.
- R9: The two read ports are independent and may read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| rd_tid | input | TID_W | Thread number for both read ports |
| rd_cwp | input | 2 | Window pointer for both read ports (0..2) |
| rd_ucode | input | 1 | Microcode mode for both read ports |
| rd_reg_a | input | 5 | Architectural register number, port A |
| rd_reg_b | input | 5 | Architectural register number, port B |
| rd_data_a | output | DATA_W | Read data, port A |
| rd_err_a | output | 1 | Parity error, port A |
| rd_data_b | output | DATA_W | Read data, port B |
| rd_err_b | output | 1 | Parity error, port B |
| wr_en | input | 1 | Write enable |
| wr_tid | input | TID_W | Thread number for the write |
| wr_cwp | input | 2 | Window pointer for the write (0..2) |
| wr_ucode | input | 1 | Microcode mode for the write |
| wr_reg | input | 5 | Architectural register number for the write |
| wr_data | input | DATA_W | Write data |

## Verification
The assertions assume that the window pointers stay in the range 0..2. The value 3 has no window, and its slot arithmetic would land on the globals. They also assume that reset is held for at least one clock before any read result is judged. The bench only ever drives pointer values 0, 1 and 2. It fills every slot of every thread through the write port before it reads any slot back, so no read returns storage that was never written.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int SLOT_W   = 6;
  localparam int NWIN     = 3;
  localparam int WIN_BASE = 16;
  localparam int WIN_SIZE = 16;

  // architectural register -> slot inside a thread's 64-entry chunk
  function automatic logic [SLOT_W-1:0] win_offset(input logic [4:0] r,
                                                   input logic [1:0] cwp,
                                                   input logic ucode);
    int ri, wi, prev, off;
    ri   = int'(r);
    wi   = int'(cwp);
    prev = (wi + NWIN - 1) % NWIN;
    if (ri < 8)
      off = ri;
    else if (ri < 16)
      off = ucode ? ri : WIN_BASE + WIN_SIZE * prev + 8 + (ri - 8);
    else
      off = WIN_BASE + WIN_SIZE * wi + (ri - 16);
    return off[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/regwin_addr_map.sv
module regwin_addr_map
  import regwin_pkg::*;
#(
  parameter int TID_W = 4
) (
  input  logic [TID_W-1:0]        tid,
  input  logic [1:0]              cwp,
  input  logic                    ucode,
  input  logic [4:0]              areg,
  output logic [TID_W+SLOT_W-1:0] paddr,
  output logic                    is_zero
);
  assign paddr   = {tid, win_offset(areg, cwp, ucode)};
  assign is_zero = (areg == 5'd0);
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int AW = 10,
  parameter int WW = 33
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [WW-1:0] q_a,
  output logic [WW-1:0] q_b
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  // read-first: the reads see the contents before this edge's write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
    q_a <= mem[raddr_a];
    q_b <= mem[raddr_b];
  end
endmodule

// File: rtl/regwin_regfile.sv
module regwin_regfile
  import regwin_pkg::*;
#(
  parameter int THREADS = 16,
  parameter int DATA_W  = 32,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int AW     = TID_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TID_W-1:0]  rd_tid,
  input  logic [1:0]        rd_cwp,
  input  logic              rd_ucode,
  input  logic [4:0]        rd_reg_a,
  input  logic [4:0]        rd_reg_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic              rd_err_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic              rd_err_b,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [1:0]        wr_cwp,
  input  logic              wr_ucode,
  input  logic [4:0]        wr_reg,
  input  logic [DATA_W-1:0] wr_data
);
  logic [AW-1:0]     ra_addr, rb_addr, st_waddr;
  logic              ra_zero, rb_zero, wr_zero;
  logic              st_we;
  logic [SLOT_W-1:0] st_woff;
  logic [DATA_W:0]   q_a, q_b;
  logic              zero_q_a, zero_q_b;

  regwin_addr_map #(.TID_W(TID_W)) u_map_a (
    .tid(rd_tid), .cwp(rd_cwp), .ucode(rd_ucode), .areg(rd_reg_a),
    .paddr(ra_addr), .is_zero(ra_zero));
  regwin_addr_map #(.TID_W(TID_W)) u_map_b (
    .tid(rd_tid), .cwp(rd_cwp), .ucode(rd_ucode), .areg(rd_reg_b),
    .paddr(rb_addr), .is_zero(rb_zero));
  regwin_addr_map #(.TID_W(TID_W)) u_map_w (
    .tid(wr_tid), .cwp(wr_cwp), .ucode(wr_ucode), .areg(wr_reg),
    .paddr(st_waddr), .is_zero(wr_zero));

  // named internal events for the checker
  assign st_we   = wr_en && !wr_zero;
  assign st_woff = st_waddr[SLOT_W-1:0];

  regwin_store #(.AW(AW), .WW(DATA_W + 1)) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wword({^wr_data, wr_data}),
    .raddr_a(ra_addr), .raddr_b(rb_addr), .q_a(q_a), .q_b(q_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q_a <= 1'b1;
      zero_q_b <= 1'b1;
    end else begin
      zero_q_a <= ra_zero;
      zero_q_b <= rb_zero;
    end
  end

  assign rd_data_a = zero_q_a ? '0 : q_a[DATA_W-1:0];
  assign rd_data_b = zero_q_b ? '0 : q_b[DATA_W-1:0];
  assign rd_err_a  = !zero_q_a && (^q_a);
  assign rd_err_b  = !zero_q_b && (^q_b);
endmodule

module regwin_chk #(
  parameter int TID_W = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] rd_reg_a,
  input logic [4:0] rd_reg_b,
  input logic       rd_zero_out_a,
  input logic       rd_zero_out_b,
  input logic       wr_en,
  input logic       wr_ucode,
  input logic [4:0] wr_reg,
  input logic [TID_W-1:0] wr_tid,
  input logic [TID_W-1:0] st_tid,
  input logic       st_we,
  input logic [5:0] st_woff
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  p_zero_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(rd_reg_a) == 5'd0) |-> rd_zero_out_a);
  p_zero_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(rd_reg_b) == 5'd0) |-> rd_zero_out_b);
  p_drop_r0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == 5'd0) |-> !st_we);
  p_we_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (wr_en && st_tid == wr_tid));
  p_scratch_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !wr_ucode) |-> (st_woff[5:3] != 3'd1));
  p_window_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && wr_reg[4]) |-> (st_woff >= 6'd16));
endmodule

bind regwin_regfile regwin_chk #(.TID_W(TID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b),
  .rd_zero_out_a(rd_data_a == '0 && !rd_err_a),
  .rd_zero_out_b(rd_data_b == '0 && !rd_err_b),
  .wr_en(wr_en), .wr_ucode(wr_ucode), .wr_reg(wr_reg), .wr_tid(wr_tid),
  .st_tid(st_waddr[AW-1:regwin_pkg::SLOT_W]), .st_we(st_we), .st_woff(st_woff));

// File: tb/sim_regwin_regfile.sv
module sim_regwin_regfile;
  localparam int THR = 4;
  localparam int TW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] rd_tid = '0, wr_tid = '0;
  logic [1:0] rd_cwp = '0, wr_cwp = '0;
  logic rd_ucode = 1'b0, wr_ucode = 1'b0, wr_en = 1'b0;
  logic [4:0] rd_reg_a = '0, rd_reg_b = '0, wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic rd_err_a, rd_err_b;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  regwin_regfile #(.THREADS(THR), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_tid(rd_tid), .rd_cwp(rd_cwp),
    .rd_ucode(rd_ucode), .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b),
    .rd_data_a(rd_data_a), .rd_err_a(rd_err_a), .rd_data_b(rd_data_b),
    .rd_err_b(rd_err_b), .wr_en(wr_en), .wr_tid(wr_tid), .wr_cwp(wr_cwp),
    .wr_ucode(wr_ucode), .wr_reg(wr_reg), .wr_data(wr_data));

  function automatic logic [31:0] pat(int t, int off);
    return {8'h5A, 8'(t), 8'(off), 8'(off * 7 + t * 3)};
  endfunction

  // bench's own slot arithmetic: window bases by table
  function automatic int base_of(int w);
    case (w)
      0: return 16;
      1: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int slot(int r, int w, bit uc);
    if (r < 8 || (uc && r < 16)) return r;
    if (r < 16) return base_of(w == 0 ? 2 : w - 1) + r;   // +8 then r-8
    return base_of(w) + r - 16;
  endfunction

  function automatic string tag(int r, bit uc);
    if (r == 0) return "R6";
    if (r < 8) return "R2";
    if (r < 16) return uc ? "R5" : "R4";
    return "R3";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int t, int w, bit uc, int r, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tid = TW'(t); wr_cwp = 2'(w); wr_ucode = uc;
    wr_reg = 5'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int t, int w, bit uc, int ra, int rb);
    @(negedge clk);
    rd_tid = TW'(t); rd_cwp = 2'(w); rd_ucode = uc;
    rd_reg_a = 5'(ra); rd_reg_b = 5'(rb);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R6 reset data a", rd_data_a, 32'h0);
    check("R8 reset err a", {31'b0, rd_err_a}, 32'h0);
    rst_n = 1'b1;

    // fill every slot 1..63 of every thread
    for (int t = 0; t < THR; t++)
      for (int off = 1; off < 64; off++) begin
        if (off < 16) wr(t, 0, 1'b1, off, pat(t, off));
        else wr(t, (off - 16) / 16, 1'b0, 16 + off % 16, pat(t, off));
      end

    // sweep: R1 thread isolation, R9 port B, R8 parity
    for (int t = 0; t < THR; t++)
      for (int w = 0; w < 3; w++)
        for (int u = 0; u < 2; u++)
          for (int r = 0; r < 32; r++) begin
            int rb = 31 - r;
            rd(t, w, bit'(u), r, rb);
            check({tag(r, bit'(u)), " R1 port a"}, rd_data_a,
                  r == 0 ? 32'h0 : pat(t, slot(r, w, bit'(u))));
            check({tag(rb, bit'(u)), " R9 port b"}, rd_data_b,
                  rb == 0 ? 32'h0 : pat(t, slot(rb, w, bit'(u))));
            check("R8 err", {30'b0, rd_err_a, rd_err_b}, 32'h0);
          end

    // R4 overlap: out under cwp 0 is in under cwp 2 (wrap); cwp 1 -> 0
    wr(1, 0, 1'b0, 9, 32'hCAFE0009);
    rd(1, 2, 1'b0, 25, 9);
    check("R4 wrap out->in", rd_data_a, 32'hCAFE0009);
    wr(1, 1, 1'b0, 15, 32'hBEEF000F);
    rd(1, 0, 1'b0, 31, 0);
    check("R4 out->in", rd_data_a, 32'hBEEF000F);
    // R5 microcode slot 8 untouched by outs
    rd(1, 0, 1'b1, 8, 9);
    check("R5 trap base", rd_data_a, pat(1, 8));
    check("R5 scratch", rd_data_b, pat(1, 9));

    // R6 write to r0 discarded, neighbours intact
    wr(2, 1, 1'b0, 0, 32'hFFFFFFFF);
    rd(2, 1, 1'b0, 0, 1);
    check("R6 r0 zero", rd_data_a, 32'h0);
    check("R6 r1 intact", rd_data_b, pat(2, 1));

    // R7 read-first on collision, then new value
    @(negedge clk);
    wr_en = 1'b1; wr_tid = 2'd3; wr_cwp = 2'd1; wr_ucode = 1'b0;
    wr_reg = 5'd17; wr_data = 32'h12345678;
    rd_tid = 2'd3; rd_cwp = 2'd1; rd_ucode = 1'b0; rd_reg_a = 5'd17; rd_reg_b = 5'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 old value", rd_data_a, pat(3, 33));
    @(negedge clk);
    check("R7 new value", rd_data_a, 32'h12345678);
    check("R8 err new", {31'b0, rd_err_a}, 32'h0);
    // R1 other thread unchanged
    rd(2, 1, 1'b0, 17, 17);
    check("R1 other thread", rd_data_a, pat(2, 33));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule